// File: doc/BRIEF.md
# Universal Counter Measurement Sequencer

This block is the measuring core of a multi-function counter. One BCD main counter and one reference counter serve six functions: frequency, period, frequency ratio, time interval, unit counting and self-measurement of the time base. A routing stage picks the event that the main counter counts and the event that the reference counter counts. The reference counter holds the gate open for 1, 10, 100 or 1000 of its own events, as the range code selects. The gate can also be driven by an external level that is sampled once per reference tick. The time base is the block clock. A divider derives the reference tick from it, dividing by `TB_DIV` or, in fine mode, by `FINE_DIV`.

The control state machine has six states. ST_ARM waits for the start event. ST_GATE counts. ST_LATCH copies the result and the overflow flag to the display register and raises `store_p`. ST_CLEAR clears the main counter and raises `rstout_p`. ST_GAP idles for `GAP_CYC` cycles. ST_HOLD keeps the main counter cleared while `hold` is high. The transitions are:
- ARM→GATE on the start event.
- GATE→LATCH on the end event.
- LATCH→CLEAR and CLEAR→GAP unconditionally.
- GAP→ARM when the gap count expires.
- ARM, GATE or GAP→HOLD on `hold`.
- HOLD→ARM when `hold` falls.
- ARM, GATE or GAP→ARM on an abort pulse or on a change of the function or range code.
- Unit mode forces ARM.

Every input event is a high-to-low transition. `clr_in` forces ARM from any state.

Top module: `ucnt_seq`

## Requirements
- R1: Function code 0 (frequency) counts falls of `sig_a` over whole reference tick periods. Code 5 (self-measure) counts clock cycles over the same window. Codes 6 and 7 behave as code 0.
- R2: Function code 1 (period) counts clock cycles over N whole periods of `sig_a`, each period running from one fall of `sig_a` to the next.
- R3: Function code 2 (ratio) counts falls of `sig_a` over N whole periods of `sig_b`.
- R4: Function code 3 (time interval) counts clock cycles from each fall of `sig_a` through the next fall of `sig_b`. The result is latched after N such intervals.
- R5: Range codes 0, 1, 2 and 3 give N = 1, 10, 100 and 1000. The tick period is `TB_DIV` cycles, or `FINE_DIV` cycles when `fine_tb` is 1.
- R6: `store_p` is high for one cycle and the display changes on the edge that ends it. `rstout_p` is high in the following cycle. `measuring` stays low from `store_p` through `GAP_CYC` further idle cycles after `rstout_p`.
- R7: Outside unit mode, `hold` stops the measurement and drives `measuring` low. No `store_p` occurs while `hold` is high, and the display keeps the last result. A full new measurement starts after `hold` is released.
- R8: A one-cycle `abort` pulse, or a change of `func_sel` or `range_sel`, discards the measurement in progress without touching the display. A new full-length measurement then starts.
- R9: Function code 4 (unit) counts every fall of `sig_a` without a gate. The display follows the count one cycle later. `hold` freezes the display while counting goes on.
- R10: `clr_in` forces the display and `ovf` to zero and restarts the cycle.
- R11: A range code of 4 or above selects external gating. The gate opens at a tick where `ext_gate` is 1 and closes at a tick where `ext_gate` is 0. Levels between ticks have no effect.
- R12: `bcd_out` holds DIGITS BCD digits, with digit i at bits [4i+3:4i] and digit 0 least significant. A carry out of the top digit wraps the counter and latches `ovf`=1 together with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_in | input | 1 | Synchronous clear of counter, display and cycle |
| sig_a | input | 1 | Measured input A |
| sig_b | input | 1 | Measured input B |
| func_sel | input | 3 | Function code |
| range_sel | input | 3 | Range code (4 and above = external gating) |
| fine_tb | input | 1 | Select the short tick divisor |
| ext_gate | input | 1 | External gate level |
| hold | input | 1 | Hold request |
| abort | input | 1 | One-cycle abort pulse |
| bcd_out | output | 4*DIGITS | Latched result digits |
| ovf | output | 1 | Latched overflow flag |
| measuring | output | 1 | High while a measurement is armed or gating |
| store_p | output | 1 | Result-store strobe |
| rstout_p | output | 1 | Counter-clear strobe |

## Verification
The assertions assume that `sig_a`, `sig_b`, `ext_gate`, `hold` and the select codes are synchronous to `clk`. They also assume that `abort` is a single-cycle pulse. The bench drives every input on the falling clock edge from one cycle counter, so every fall lands on a known rising edge. The periods are chosen to divide the gate window exactly, so each expected count has no ±1 ambiguity. Each configuration change comes with a `clr_in` pulse, except in the tests that deliberately change a code mid-gate. The external-gate edges and glitches are placed several cycles away from any tick.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    typedef enum logic [2:0] {
        FN_FREQ   = 3'd0,
        FN_PERIOD = 3'd1,
        FN_RATIO  = 3'd2,
        FN_TIVL   = 3'd3,
        FN_UNIT   = 3'd4,
        FN_OSC    = 3'd5
    } fn_e;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_GATE,
        ST_LATCH,
        ST_CLEAR,
        ST_GAP,
        ST_HOLD
    } st_e;

endpackage

// File: rtl/ucnt_tick_gen.sv
module ucnt_tick_gen #(
    parameter int TB_DIV   = 100000,
    parameter int FINE_DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fine,
    output logic tick
);
    localparam int W = $clog2(TB_DIV);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    assign lim  = fine ? W'(FINE_DIV - 1) : W'(TB_DIV - 1);
    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (restart)  cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ucnt_fall_det.sv
module ucnt_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= din[i];
        end
        assign fall[i] = prev_q & ~din[i];
    end
endmodule

// File: rtl/ucnt_bcd_ctr.sv
module ucnt_bcd_ctr #(
    parameter int DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   value,
    output logic                  ovf
);
    logic [DIGITS:0] carry;
    assign carry[0] = inc;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [3:0] d_q;
        assign carry[i+1]      = carry[i] && (d_q == 4'd9);
        assign value[4*i +: 4] = d_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        d_q <= 4'd0;
            else if (clr)      d_q <= 4'd0;
            else if (carry[i]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end

        p_digit_bcd_r12: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (d_q <= 4'd9));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ovf <= 1'b0;
        else if (clr)           ovf <= 1'b0;
        else if (carry[DIGITS]) ovf <= 1'b1;
    end
endmodule

// File: rtl/ucnt_ref_ctr.sv
module ucnt_ref_ctr #(
    parameter int RANGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ev,
    input  logic [2:0] range_code,
    output logic       done
);
    localparam int MAXT = 10 ** (RANGES - 1);
    localparam int W    = $clog2(MAXT + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] target;
    logic [W:0]   cnt_p1;

    always_comb begin
        target = W'(1);
        for (int i = 0; i < RANGES - 1; i++) begin
            if (32'(i) < 32'(range_code)) target = target * W'(10);
        end
    end

    assign cnt_p1 = {1'b0, cnt_q} + 1'b1;
    assign done   = ev && (cnt_p1 >= {1'b0, target});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (ev && !done) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ucnt_seq.sv
module ucnt_seq
    import ucnt_pkg::*;
#(
    parameter int DIGITS   = 8,
    parameter int TB_DIV   = 100000,
    parameter int FINE_DIV = TB_DIV / 10,
    parameter int GAP_CYC  = 2000000,
    parameter int RANGES   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_in,
    input  logic                sig_a,
    input  logic                sig_b,
    input  logic [2:0]          func_sel,
    input  logic [2:0]          range_sel,
    input  logic                fine_tb,
    input  logic                ext_gate,
    input  logic                hold,
    input  logic                abort,
    output logic [4*DIGITS-1:0] bcd_out,
    output logic                ovf,
    output logic                measuring,
    output logic                store_p,
    output logic                rstout_p
);
    localparam int GW = $clog2(GAP_CYC + 1);

    st_e  st, nxt;
    fn_e  fn;
    logic is_unit, is_ext;
    logic fa, fb, tick;
    logic [2:0] func_q, range_q;
    logic cfg_chg, restart;
    logic start_ev, end_ev, ref_ev, ref_done;
    logic main_inc, main_clr, main_ovf;
    logic [4*DIGITS-1:0] main_val;
    logic ti_open_q;
    logic [GW-1:0] gap_cnt_q;
    logic gap_done;
    logic [4*DIGITS-1:0] disp_q;
    logic ovf_q;

    // ---- decode of selections ----
    assign fn      = (func_sel > 3'd5) ? FN_FREQ : fn_e'(func_sel);
    assign is_unit = (fn == FN_UNIT);
    assign is_ext  = (32'(range_sel) >= RANGES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q  <= '0;
            range_q <= '0;
        end else begin
            func_q  <= func_sel;
            range_q <= range_sel;
        end
    end
    assign cfg_chg = (func_q != func_sel) || (range_q != range_sel);
    assign restart = abort || cfg_chg;

    // ---- sub-blocks ----
    ucnt_fall_det #(.N(2)) u_fall (
        .clk (clk), .rst_n (rst_n),
        .din ({sig_b, sig_a}), .fall ({fb, fa})
    );

    ucnt_tick_gen #(.TB_DIV(TB_DIV), .FINE_DIV(FINE_DIV)) u_tick (
        .clk (clk), .rst_n (rst_n), .restart (clr_in),
        .fine (fine_tb), .tick (tick)
    );

    ucnt_ref_ctr #(.RANGES(RANGES)) u_ref (
        .clk (clk), .rst_n (rst_n), .clr (st != ST_GATE),
        .ev (ref_ev && st == ST_GATE), .range_code (range_sel), .done (ref_done)
    );

    ucnt_bcd_ctr #(.DIGITS(DIGITS)) u_main (
        .clk (clk), .rst_n (rst_n), .clr (main_clr), .inc (main_inc),
        .value (main_val), .ovf (main_ovf)
    );

    // ---- per-function routing ----
    always_comb begin
        ref_ev   = 1'b0;
        start_ev = 1'b0;
        main_inc = 1'b0;
        unique case (fn)
            FN_FREQ: begin
                ref_ev = tick; start_ev = tick;
                main_inc = (st == ST_GATE) && fa;
            end
            FN_PERIOD: begin
                ref_ev = fa; start_ev = fa;
                main_inc = (st == ST_GATE);
            end
            FN_RATIO: begin
                ref_ev = fb; start_ev = fb;
                main_inc = (st == ST_GATE) && fa;
            end
            FN_TIVL: begin
                ref_ev = fb && ti_open_q; start_ev = fa;
                main_inc = (st == ST_GATE) && ti_open_q;
            end
            FN_UNIT: begin
                main_inc = fa;
            end
            FN_OSC: begin
                ref_ev = tick; start_ev = tick;
                main_inc = (st == ST_GATE);
            end
            default: ;
        endcase
        if (is_ext) start_ev = tick && ext_gate;
    end

    assign end_ev   = is_ext ? (tick && !ext_gate) : ref_done;
    assign main_clr = clr_in || restart || (st == ST_CLEAR) || (st == ST_HOLD);

    // time-interval window flag: opens on A fall, closes on B fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ti_open_q <= 1'b0;
        else if (clr_in)            ti_open_q <= 1'b0;
        else if (st == ST_ARM)      ti_open_q <= (fn == FN_TIVL) && !is_ext && fa;
        else if (st == ST_GATE) begin
            if (fb && ti_open_q)    ti_open_q <= 1'b0;
            else if (fa)            ti_open_q <= 1'b1;
        end else                    ti_open_q <= 1'b0;
    end

    // ---- inter-measurement gap timer ----
    assign gap_done = (gap_cnt_q == GW'(GAP_CYC - 1));
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap_cnt_q <= '0;
        else if (st != ST_GAP) gap_cnt_q <= '0;
        else                   gap_cnt_q <= gap_cnt_q + 1'b1;
    end

    // ---- state machine ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st <= ST_ARM;
        else if (clr_in) st <= ST_ARM;
        else             st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (is_unit) begin
            nxt = ST_ARM;
        end else begin
            unique case (st)
                ST_ARM: begin
                    if (hold)          nxt = ST_HOLD;
                    else if (restart)  nxt = ST_ARM;
                    else if (start_ev) nxt = ST_GATE;
                end
                ST_GATE: begin
                    if (hold)          nxt = ST_HOLD;
                    else if (restart)  nxt = ST_ARM;
                    else if (end_ev)   nxt = ST_LATCH;
                end
                ST_LATCH: nxt = ST_CLEAR;
                ST_CLEAR: nxt = ST_GAP;
                ST_GAP: begin
                    if (hold)          nxt = ST_HOLD;
                    else if (restart)  nxt = ST_ARM;
                    else if (gap_done) nxt = ST_ARM;
                end
                ST_HOLD: begin
                    if (!hold)         nxt = ST_ARM;
                end
                default: nxt = ST_ARM;
            endcase
        end
    end

    // ---- output decode ----
    always_comb begin
        measuring = 1'b0;
        store_p   = 1'b0;
        rstout_p  = 1'b0;
        unique case (st)
            ST_ARM, ST_GATE: measuring = 1'b1;
            ST_LATCH:        store_p   = 1'b1;
            ST_CLEAR:        rstout_p  = 1'b1;
            ST_GAP, ST_HOLD: ;
            default: ;
        endcase
        if (is_unit) measuring = 1'b1;
    end

    // ---- display latch ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clr_in) begin
            disp_q <= '0;
            ovf_q  <= 1'b0;
        end else if (is_unit) begin
            if (!hold) begin
                disp_q <= main_val;
                ovf_q  <= main_ovf;
            end
        end else if (st == ST_LATCH) begin
            disp_q <= main_val;
            ovf_q  <= main_ovf;
        end
    end

    assign bcd_out = disp_q;
    assign ovf     = ovf_q;

    // ---- assertions ----
    p_store_then_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || clr_in)
        store_p |=> rstout_p);

    p_store_after_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_p |-> $past(measuring));

    p_hold_blocks_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !is_unit) |=> !store_p);

    p_unit_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_unit && hold && !clr_in) |=> $stable(bcd_out));

    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_in |=> (bcd_out == '0 && !ovf));

    p_ext_close_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GATE && is_ext && !tick) |=> !store_p);
endmodule

// File: tb/ucnt_seq_tb.sv
module ucnt_seq_tb;
    localparam int DIGITS = 4;
    localparam int W = 4 * DIGITS;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, clr_in = 1'b0;
    logic a_man = 1'b1;
    logic sig_a, sig_b;
    logic [2:0] func_sel = 3'd0, range_sel = 3'd0;
    logic fine_tb = 1'b0, ext_gate = 1'b0, hold = 1'b0, abort = 1'b0;
    logic [W-1:0] bcd_out;
    logic ovf, measuring, store_p, rstout_p;

    int cyc = 0;
    int a_per = 4, b_per = 0, b_off = 0;
    int nvec = 0, nerr = 0;
    bit finished = 1'b0;

    logic [W:0] exp_q[$];
    string      tag_q[$];

    always @(negedge clk) cyc <= cyc + 1;
    assign sig_a = (a_per == 0) ? a_man : ((cyc % a_per) < a_per / 2);
    assign sig_b = (b_per == 0) ? 1'b1 : (((cyc + b_per - b_off) % b_per) < b_per / 2);

    ucnt_seq #(.DIGITS(DIGITS), .TB_DIV(20), .FINE_DIV(2), .GAP_CYC(8), .RANGES(4)) u_dut (
        .clk (clk), .rst_n (rst_n), .clr_in (clr_in), .sig_a (sig_a), .sig_b (sig_b),
        .func_sel (func_sel), .range_sel (range_sel), .fine_tb (fine_tb),
        .ext_gate (ext_gate), .hold (hold), .abort (abort),
        .bcd_out (bcd_out), .ovf (ovf), .measuring (measuring),
        .store_p (store_p), .rstout_p (rstout_p)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compare each stored result when the clear strobe shows it
    always @(negedge clk) begin
        if (rst_n && rstout_p && exp_q.size() > 0) begin
            logic [W:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nvec++;
            if ({ovf, bcd_out} !== e) begin
                nerr++;
                $display("FAIL %s: actual ovf=%0b bcd=%0h expected ovf=%0b bcd=%0h",
                         t, ovf, bcd_out, e[W], e[W-1:0]);
            end
        end
    end

    task automatic expect_res(input int v, input bit o, input string req);
        exp_q.push_back({o, to_bcd(v)});
        tag_q.push_back(req);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic setup(input int f, input int r, input bit fine);
        @(negedge clk);
        func_sel = 3'(f);
        range_sel = 3'(r);
        fine_tb = fine;
        clr_in = 1'b1;
        @(negedge clk);
        clr_in = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10)
        check("R10 reset bcd", int'(bcd_out), 0);
        check("R10 reset ovf", int'(ovf), 0);
        check("R6 reset strobes", int'({store_p, rstout_p}), 0);

        // frequency and range (R1, R5)
        a_per = 4;
        setup(0, 0, 0); expect_res(5, 1'b0, "R1 freq r0");
        setup(0, 1, 0); expect_res(50, 1'b0, "R5 freq r1");
        setup(7, 0, 0); expect_res(5, 1'b0, "R1 code7 as freq");
        setup(5, 0, 0); expect_res(20, 1'b0, "R1 osc r0");

        // end-of-measurement sequence (R6)
        while (!store_p) @(negedge clk);
        check("R6 measuring low at store", int'(measuring), 0);
        k = 0;
        @(negedge clk);
        k++;
        check("R6 clear strobe follows store", int'(rstout_p), 1);
        while (!measuring) begin @(negedge clk); k++; end
        check("R6 idle length", k, 10);

        setup(5, 0, 1); expect_res(2, 1'b0, "R5 fine tick");

        // period (R2)
        a_per = 6;
        setup(1, 0, 0); expect_res(6, 1'b0, "R2 period r0");
        setup(1, 1, 0); expect_res(60, 1'b0, "R2 period r1");

        // abort (R8)
        repeat (30) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        k = 1;
        while (!store_p) begin @(negedge clk); k++; end
        check("R8 abort restarts full gate", int'(k >= 60), 1);
        expect_res(60, 1'b0, "R8 result after abort");
        // range change mid-gate (R8)
        repeat (30) @(negedge clk);
        range_sel = 3'd0;
        expect_res(6, 1'b0, "R8 range change restart");

        // ratio (R3)
        a_per = 2; b_per = 10; b_off = 0;
        setup(2, 1, 0); expect_res(50, 1'b0, "R3 ratio r1");

        // time interval (R4)
        a_per = 20; b_per = 20; b_off = 7;
        setup(3, 0, 0); expect_res(7, 1'b0, "R4 interval r0");
        setup(3, 1, 0); expect_res(70, 1'b0, "R4 interval r1");
        b_per = 0;

        // hold outside unit mode (R7)
        a_per = 4;
        setup(0, 1, 0); expect_res(50, 1'b0, "R7 before hold");
        repeat (40) @(negedge clk);
        hold = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 measuring low in hold", int'(measuring), 0);
        k = 0;
        repeat (250) begin @(negedge clk); if (store_p) k++; end
        check("R7 no store during hold", k, 0);
        check("R7 display kept", int'(bcd_out), int'(to_bcd(50)));
        hold = 1'b0;
        expect_res(50, 1'b0, "R7 after release");

        // external gating (R11)
        ext_gate = 1'b1;
        setup(0, 4, 0);
        repeat (44) @(negedge clk);
        ext_gate = 1'b0;
        repeat (3) @(negedge clk);
        ext_gate = 1'b1;
        repeat (22) @(negedge clk);
        ext_gate = 1'b0;
        expect_res(15, 1'b0, "R11 external gate");

        // unit counter (R9)
        @(negedge clk);
        a_per = 0; a_man = 1'b1;
        setup(4, 0, 0);
        repeat (37) begin @(negedge clk); a_man = 1'b0; @(negedge clk); a_man = 1'b1; end
        repeat (3) @(negedge clk);
        check("R9 unit count", int'(bcd_out), int'(to_bcd(37)));
        hold = 1'b1;
        repeat (5) begin @(negedge clk); a_man = 1'b0; @(negedge clk); a_man = 1'b1; end
        repeat (3) @(negedge clk);
        check("R9 display frozen", int'(bcd_out), int'(to_bcd(37)));
        hold = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 count continued", int'(bcd_out), int'(to_bcd(42)));

        // overflow (R12) then clear (R10)
        a_per = 4;
        setup(5, 3, 0); expect_res(0, 1'b1, "R12 overflow");
        check("R12 ovf held", int'(ovf), 1);
        @(negedge clk);
        clr_in = 1'b1;
        @(negedge clk);
        clr_in = 1'b0;
        check("R10 clr bcd", int'(bcd_out), 0);
        check("R10 clr ovf", int'(ovf), 0);

        finish_run();
    end
endmodule